// File: doc/BRIEF.md
# External Interrupt Input Sampler

This block turns active-low external interrupt pins into interrupt request flags for an interrupt arbiter. Each channel passes its raw pin through a two-flop synchronizer. An internal machine-cycle strobe marks one oscillator clock in every `CYCLE_LEN` clocks, and the synchronized level is sampled only on that clock. The flag is therefore ready for the arbiter to examine in the following machine cycle.

A mode input per channel selects how the flag is set. In level mode the flag tracks the inverted sample at each machine cycle. In edge mode the flag is set when one sample is high and the next sample is low, and it then stays set until it is cleared. Clearing happens when the controller acknowledges the channel on vectoring. Software can also write the flag directly, but a hardware set in the same clock wins over any clear.

Top module: `ext_irq_sampler`

## Requirements
- R1: `mcStrobe` is high for exactly one clock in every `CYCLE_LEN` clocks (default 12). The first strobe comes on the `CYCLE_LEN`-th rising edge after reset is released.
- R2: The pin reaches the sampler through two synchronizer flops. The flag reacts to the pin only on a strobe edge, so a pin change is not visible before the next strobe.
- R3: In level mode (`modeEdge` bit = 0), after each strobe edge the flag equals the inverse of the sampled pin: it is 1 for a low pin and 0 for a high pin.
- R4: In edge mode (`modeEdge` bit = 1), the flag is set at a strobe edge when the previous sample was high and the new sample is low. Once set, it stays set while the pin rises or stays low.
- R5: In edge mode, a low pulse that starts and ends between two strobes is not caught. A pin held high for one machine cycle and then low for one machine cycle sets the flag.
- R6: An `ackIn` bit high for one clock clears that channel's flag, and the clear is visible after that clock edge.
- R7: In level mode, a flag that is acknowledged while the pin is still low is set again at the next strobe edge.
- R8: With `swWrEn` high for a channel, the flag takes the value of `swWrData` for that channel on the next clock edge.
- R9: A hardware set at a strobe edge takes precedence over a software write of 0 or an acknowledge in the same clock.
- R10: After reset all flags are 0. A pin held low through reset in edge mode does not set the flag, because the first sample after reset only primes the edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinN | input | CHANNELS | Raw active-low interrupt pins |
| modeEdge | input | CHANNELS | Per-channel trigger mode: 1 = falling edge, 0 = low level |
| ackIn | input | CHANNELS | Acknowledge from the controller on vectoring; clears the flag |
| swWrEn | input | CHANNELS | Software write enable for the flag |
| swWrData | input | CHANNELS | Value written to the flag by software |
| mcStrobe | output | 1 | Machine-cycle strobe; the sample clock |
| reqFlag | output | CHANNELS | Interrupt request flags |

## Verification
A stale or wrongly reset edge-history bit shows at the ports as a flag that sets one machine cycle late, one machine cycle early, or not at all. This includes a false request straight after reset. A miscounted machine-cycle counter moves the strobe, and the flag then changes at the wrong clock within the first twelve clocks. A wrong set/clear priority in the flag register shows in the clock right after a coincident acknowledge or write. For these reasons the checks sample the flag on the clock just before and the clock just after a strobe edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  // Strobes from the cycle control to the per-channel datapath.
  typedef struct packed {
    logic sampleEn;  // take a new machine-cycle sample this clock
    logic edgeEn;    // the edge history is valid (not the first sample)
  } irqStrobe_t;

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int STAGES   = 2,
  parameter bit RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic dIn,
  output logic qOut
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], dIn};
  end

  assign qOut = chain[STAGES-1];
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int CYCLE_LEN = 12
) (
  input  logic       clk,
  input  logic       rstN,
  output irqStrobe_t strb
);
  localparam int CW = (CYCLE_LEN > 1) ? $clog2(CYCLE_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLE_LEN - 1);

  logic [CW-1:0] phaseCnt;
  logic          armed;
  logic          atLast;

  assign atLast = (phaseCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
      armed    <= 1'b0;
    end else begin
      phaseCnt <= atLast ? '0 : phaseCnt + 1'b1;
      if (atLast) armed <= 1'b1;
    end
  end

  assign strb.sampleEn = atLast;
  assign strb.edgeEn   = atLast & armed;
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int CHANNELS    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  irqStrobe_t          strb,
  input  logic [CHANNELS-1:0] pinN,
  input  logic [CHANNELS-1:0] modeEdge,
  input  logic [CHANNELS-1:0] ackIn,
  input  logic [CHANNELS-1:0] swWrEn,
  input  logic [CHANNELS-1:0] swWrData,
  output logic [CHANNELS-1:0] reqFlag
);
  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic syncPin;
    logic sampleQ;
    logic flagQ;
    logic hwSet;
    logic lvlDrop;

    ext_irq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) uSync (
      .clk  (clk),
      .rstN (rstN),
      .dIn  (pinN[ch]),
      .qOut (syncPin)
    );

    always_comb begin
      if (modeEdge[ch]) begin
        hwSet   = strb.edgeEn & sampleQ & ~syncPin;
        lvlDrop = 1'b0;
      end else begin
        hwSet   = strb.sampleEn & ~syncPin;
        lvlDrop = strb.sampleEn & syncPin;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sampleQ <= 1'b1;
        flagQ   <= 1'b0;
      end else begin
        if (strb.sampleEn) sampleQ <= syncPin;
        if (hwSet)                   flagQ <= 1'b1;
        else if (swWrEn[ch])         flagQ <= swWrData[ch];
        else if (ackIn[ch] | lvlDrop) flagQ <= 1'b0;
      end
    end

    assign reqFlag[ch] = flagQ;
  end
endmodule

// File: rtl/ext_irq_sampler.sv
module ext_irq_sampler
  import ext_irq_pkg::*;
#(
  parameter int CHANNELS    = 2,
  parameter int CYCLE_LEN   = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CHANNELS-1:0] pinN,
  input  logic [CHANNELS-1:0] modeEdge,
  input  logic [CHANNELS-1:0] ackIn,
  input  logic [CHANNELS-1:0] swWrEn,
  input  logic [CHANNELS-1:0] swWrData,
  output logic                mcStrobe,
  output logic [CHANNELS-1:0] reqFlag
);
  irqStrobe_t strb;

  ext_irq_ctrl #(.CYCLE_LEN(CYCLE_LEN)) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  ext_irq_datapath #(.CHANNELS(CHANNELS), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pinN     (pinN),
    .modeEdge (modeEdge),
    .ackIn    (ackIn),
    .swWrEn   (swWrEn),
    .swWrData (swWrData),
    .reqFlag  (reqFlag)
  );

  assign mcStrobe = strb.sampleEn;
endmodule

// File: rtl/ext_irq_chk.sv
module ext_irq_chk #(
  parameter int CHANNELS  = 2,
  parameter int CYCLE_LEN = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic [CHANNELS-1:0] modeEdge,
  input logic [CHANNELS-1:0] ackIn,
  input logic [CHANNELS-1:0] swWrEn,
  input logic [CHANNELS-1:0] swWrData,
  input logic                mcStrobe,
  input logic [CHANNELS-1:0] reqFlag
);
  localparam int CW = $clog2(CYCLE_LEN + 1);
  logic [CW-1:0] gap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          gap <= '0;
    else if (mcStrobe)  gap <= '0;
    else                gap <= gap + 1'b1;
  end

  // R1: strobe spacing
  p_strobe_period_r1: assert property (@(posedge clk) disable iff (!rstN)
    mcStrobe == (gap == CW'(CYCLE_LEN - 1)));

  // R10: flags clear as reset is released
  p_reset_clear_r10: assert property (@(posedge clk)
    $rose(rstN) |-> (reqFlag == '0));

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chk
    // R2: no flag movement off the strobe without ack or write
    p_hold_off_strobe_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!mcStrobe && !ackIn[ch] && !swWrEn[ch]) |=> (reqFlag[ch] == $past(reqFlag[ch])));

    // R4: edge-mode flag stays latched
    p_edge_latched_r4: assert property (@(posedge clk) disable iff (!rstN)
      (modeEdge[ch] && reqFlag[ch] && !ackIn[ch] && !swWrEn[ch]) |=> reqFlag[ch]);

    // R6: acknowledge clears off the strobe
    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ackIn[ch] && !swWrEn[ch] && !mcStrobe) |=> !reqFlag[ch]);

    // R8: software write off the strobe
    p_sw_write_r8: assert property (@(posedge clk) disable iff (!rstN)
      (swWrEn[ch] && !mcStrobe) |=> (reqFlag[ch] == $past(swWrData[ch])));
  end
endmodule

bind ext_irq_sampler ext_irq_chk #(.CHANNELS(CHANNELS), .CYCLE_LEN(CYCLE_LEN)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .modeEdge (modeEdge),
  .ackIn    (ackIn),
  .swWrEn   (swWrEn),
  .swWrData (swWrData),
  .mcStrobe (mcStrobe),
  .reqFlag  (reqFlag)
);

// File: tb/tb_ext_irq_sampler.sv
`timescale 1ns/1ps
module tb_ext_irq_sampler;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pinN = 2'b11;
  logic [1:0] modeEdge = 2'b11;
  logic [1:0] ackIn = 2'b00;
  logic [1:0] swWrEn = 2'b00;
  logic [1:0] swWrData = 2'b00;
  logic       mcStrobe;
  logic [1:0] reqFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;

  ext_irq_sampler dut (
    .clk(clk), .rstN(rstN), .pinN(pinN), .modeEdge(modeEdge), .ackIn(ackIn),
    .swWrEn(swWrEn), .swWrData(swWrData), .mcStrobe(mcStrobe), .reqFlag(reqFlag)
  );

  // {mode, pin, ack, expected flag} for channel 0, one machine cycle each
  localparam logic [3:0] VEC [15] = '{
    4'b1100, 4'b1001, 4'b1001, 4'b1010, 4'b1100,
    4'b1100, 4'b1001, 4'b1101, 4'b1110, 4'b0100,
    4'b0001, 4'b0011, 4'b0100, 4'b0001, 4'b0100
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishRun;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  endtask

  // Ends on the falling edge just after the next strobe edge.
  task automatic stepMc;
    do @(negedge clk); while (!mcStrobe);
    @(negedge clk);
  endtask

  task automatic ackPulse;
    ackIn[0] = 1'b1;
    @(negedge clk);
    ackIn[0] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected finish");
      finishRun();
    end
  end

  initial begin
    int gapCnt;
    // R10: pin 0 held low through reset in edge mode
    pinN = 2'b10;
    repeat (4) @(negedge clk);
    chk("R10 reset flag ch0", reqFlag[0], 1'b0);
    chk("R10 reset flag ch1", reqFlag[1], 1'b0);
    rstN = 1'b1;

    // R1: strobe period
    do @(negedge clk); while (!mcStrobe);
    gapCnt = 0;
    do begin @(negedge clk); gapCnt++; end while (!mcStrobe);
    nChecks++;
    if (gapCnt != 12) begin
      nFails++;
      $display("FAIL R1 strobe period: actual %0d expected 12", gapCnt);
    end
    @(negedge clk);
    stepMc();
    chk("R10 no false edge ch0", reqFlag[0], 1'b0);
    chk("R10 no false edge ch1", reqFlag[1], 1'b0);

    // Vector table walk: R3 R4 R6 R7
    for (int i = 0; i < 15; i++) begin
      string tag;
      modeEdge[0] = VEC[i][3];
      pinN[0]     = VEC[i][2];
      if (VEC[i][3]) tag = VEC[i][1] ? "R6 edge ack" : "R4 edge";
      else           tag = VEC[i][1] ? "R7 level rerequest" : "R3 level";
      if (VEC[i][1]) ackPulse();
      stepMc();
      chk(tag, reqFlag[0], VEC[i][0]);
      chk("R4 idle channel 1", reqFlag[1], 1'b0);
    end

    // R2: level mode, pin low not seen before the strobe edge
    modeEdge[0] = 1'b0;
    pinN[0] = 1'b1;
    stepMc();
    pinN[0] = 1'b0;
    do @(negedge clk); while (!mcStrobe);
    chk("R2 before strobe", reqFlag[0], 1'b0);
    @(negedge clk);
    chk("R3 after strobe", reqFlag[0], 1'b1);

    // R5: short pulse missed, full pulse caught
    modeEdge[0] = 1'b1;
    pinN[0] = 1'b1;
    ackPulse();
    stepMc();
    chk("R6 clear before pulse test", reqFlag[0], 1'b0);
    pinN[0] = 1'b0;
    repeat (3) @(negedge clk);
    pinN[0] = 1'b1;
    stepMc();
    chk("R5 short pulse missed", reqFlag[0], 1'b0);
    pinN[0] = 1'b0;
    stepMc();
    chk("R5 full pulse caught", reqFlag[0], 1'b1);

    // R9: hardware set against a software clear and an ack in the same clock
    pinN[0] = 1'b1;
    ackPulse();
    stepMc();
    chk("R6 clear before priority test", reqFlag[0], 1'b0);
    pinN[0] = 1'b0;
    do @(negedge clk); while (!mcStrobe);
    swWrEn[0] = 1'b1; swWrData[0] = 1'b0; ackIn[0] = 1'b1;
    @(negedge clk);
    swWrEn[0] = 1'b0; ackIn[0] = 1'b0;
    chk("R9 hw set wins", reqFlag[0], 1'b1);

    // R8: software writes between strobes
    pinN[0] = 1'b1;
    ackPulse();
    chk("R6 ack mid cycle", reqFlag[0], 1'b0);
    swWrEn[0] = 1'b1; swWrData[0] = 1'b1;
    @(negedge clk);
    swWrEn[0] = 1'b0;
    chk("R8 sw set", reqFlag[0], 1'b1);
    swWrEn[0] = 1'b1; swWrData[0] = 1'b0;
    @(negedge clk);
    swWrEn[0] = 1'b0;
    chk("R8 sw clear", reqFlag[0], 1'b0);

    done = 1;
    finishRun();
  end
endmodule